// File: doc/BRIEF.md
# Priority-Level Interrupt Controller

This block collects interrupt requests from two kinds of source and presents one of them at a time to a processor core. Critical sources always run at level 3. They latch a one-cycle event pulse and cannot be masked or disabled. External sources come in on active-low request pins.

Each external source has its own 2-bit priority field and its own sensing-mode bit. A field of 00 turns the source off completely. Any other field value selects level (field − 1), which gives levels 0, 1 or 2. A 2-bit threshold then masks whole levels below its value. Levels 0 to 2 are affected by the threshold; level 3 never is.

The controller outputs the winning request and its level. When the core acknowledges it, the level is recorded as in service. From then on, only a strictly higher level can be presented. An end-of-service pulse retires the most recently entered level, so that nested service unwinds in order.

Sources are numbered as follows: critical source c is number c, and external source k is number N_CRIT + k.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_valid` and `svc_active` are 0, and no request is pending.
- R2: External priority field encoding (`ext_prio[2k+1:2k]`):
  - 00 disables the source.
  - 01, 10 and 11 give levels 0, 1 and 2.
  - The presented level appears on `irq_level`.
- R3: Threshold `mask_thr` = t lets a level 0..2 request through only when its level is ≥ t. A value of 11 blocks every level below 3, and 00 blocks nothing.
- R4: A high pulse on `crit_evt[c]` latches a level-3 request for source c. The request is presented whatever the threshold is, and it stays pending until it is acknowledged.
- R5: With `ext_mode[k]` = 0 (low-level sensing), the source is presented one clock after its pin is sampled low. It is withdrawn one clock after the pin is sampled high.
- R6: With `ext_mode[k]` = 1 (falling-edge sensing):
  - A falling edge is latched as pending and survives the pin returning high.
  - An acknowledge of that source clears it.
  - An edge seen while the source's field is 00 is discarded.
- R7: Among eligible requests, the highest level wins. Between equal levels, the lower source number wins (`irq_src`).
- R8: `ack` while `irq_valid` is 1 enters `irq_level` into service. From the next clock, `svc_active` is 1 and `svc_level` shows that level.
- R9: While a level is in service, only requests of a strictly higher level are presented.
- R10: `eoi` retires the most recently entered (highest) in-service level. `svc_level` falls back to the previous one, and `svc_active` drops once none remain.
- R11: `ack` while `irq_valid` is 0 has no effect on the service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crit_evt | input | N_CRIT | Level-3 event pulses, one per critical source |
| ext_req_n | input | N_EXT | Active-low external request pins |
| ext_mode | input | N_EXT | Per source: 0 = low-level sensing, 1 = falling-edge sensing |
| ext_prio | input | 2*N_EXT | Per source 2-bit priority field |
| mask_thr | input | 2 | Level mask threshold |
| ack | input | 1 | Acknowledge of the presented request |
| eoi | input | 1 | End of the current service level |
| irq_valid | output | 1 | A request is presented |
| irq_src | output | SRC_W | Number of the presented source |
| irq_level | output | 2 | Level of the presented source |
| svc_active | output | 1 | At least one level is in service |
| svc_level | output | 2 | Highest level in service |

## Verification
The bench sweeps every combination of priority field and threshold for one source, which targets an off-by-one in the field-to-level mapping. A design with that fault would let field 11 through under threshold 11, or treat field 00 as level 0.

A second sweep over all pairs of fields checks tie-breaking, where a design with reversed scanning would grant the higher-numbered source. The edge mode is exercised both with a pulse that ends before it is observed and with an edge that arrives while the source is disabled. The disabled-source case exposes a design that lets a stale edge surface after re-enabling.

A nested sequence stacks levels 1, 2 and 3 and then unwinds them. This catches a design that presents equal levels during service or pops the wrong level.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_TOP = 2'd3;

  // A field of 00 switches the source off.
  function automatic logic field_on(input logic [1:0] fld);
    return fld != 2'b00;
  endfunction

  // Non-zero field values map to the level one below them.
  function automatic lvl_t field_to_lvl(input logic [1:0] fld);
    return fld - 2'd1;
  endfunction

endpackage

// File: rtl/irq_sense.sv
module irq_sense #(
  parameter int N_EXT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] req_n,
  input  logic [N_EXT-1:0] mode,
  input  logic [N_EXT-1:0] enable,
  input  logic [N_EXT-1:0] clr,
  output logic [N_EXT-1:0] pend
);

  for (genvar k = 0; k < N_EXT; k++) begin : g_src
    logic smp_q, smp_qq;
    logic edge_q, edge_d;
    logic fall;

    always_comb begin
      fall   = smp_qq & ~smp_q;
      edge_d = edge_q;
      if (clr[k])               edge_d = 1'b0;
      if (fall)                 edge_d = 1'b1;
      if (!enable[k] || !mode[k]) edge_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        smp_q  <= 1'b1;
        smp_qq <= 1'b1;
        edge_q <= 1'b0;
      end else begin
        smp_q  <= req_n[k];
        smp_qq <= smp_q;
        edge_q <= edge_d;
      end
    end

    assign pend[k] = enable[k] & (mode[k] ? edge_q : ~smp_q);

    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[k] && enable[k] && edge_q && !clr[k]) |=> edge_q); // R6
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_SRC = 6,
  parameter int SRC_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_SRC-1:0]      req,
  input  logic [N_SRC-1:0][1:0] lvl,
  input  lvl_t                  thr,
  input  logic                  svc_active,
  input  lvl_t                  svc_level,
  output logic                  valid,
  output logic [SRC_W-1:0]      src,
  output lvl_t                  level
);

  logic [N_SRC-1:0] elig;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      elig[i] = req[i]
              && (lvl[i] == LVL_TOP || lvl[i] >= thr)
              && (!svc_active || lvl[i] > svc_level);
    end
  end

  // Scan from the top index down, so that a lower index overwrites on a tie.
  always_comb begin
    valid = 1'b0;
    src   = '0;
    level = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i] && (!valid || lvl[i] >= level)) begin
        valid = 1'b1;
        src   = SRC_W'(i);
        level = lvl[i];
      end
    end
  end

  AST_THRESHOLD_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (level == LVL_TOP || level >= thr)); // R3
  AST_PREEMPT_ONLY_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && svc_active) |-> (level > svc_level)); // R9

endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track
  import irq_pkg::*;
#(
  parameter int N_LVL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  lvl_t push_level,
  input  logic pop,
  output logic active,
  output lvl_t level
);

  logic [N_LVL-1:0] mask_q, mask_d, top_oh;

  always_comb begin
    level = '0;
    for (int j = 0; j < N_LVL; j++) begin
      if (mask_q[j]) level = lvl_t'(j);
    end
    active = |mask_q;
    top_oh = active ? (N_LVL'(1) << level) : '0;
  end

  always_comb begin
    mask_d = mask_q;
    if (pop)  mask_d = mask_d & ~top_oh;
    if (push) mask_d = mask_d | (N_LVL'(1) << push_level);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  AST_PUSH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (active && level == $past(push_level))); // R8
  AST_POP_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && active) |=> (!active || level < $past(level))); // R10

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_CRIT = 2,
  parameter int N_EXT  = 4,
  localparam int N_SRC = N_CRIT + N_EXT,
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CRIT-1:0]  crit_evt,
  input  logic [N_EXT-1:0]   ext_req_n,
  input  logic [N_EXT-1:0]   ext_mode,
  input  logic [2*N_EXT-1:0] ext_prio,
  input  logic [1:0]         mask_thr,
  input  logic               ack,
  input  logic               eoi,
  output logic               irq_valid,
  output logic [SRC_W-1:0]   irq_src,
  output logic [1:0]         irq_level,
  output logic               svc_active,
  output logic [1:0]         svc_level
);

  logic                  ack_ok;
  logic [N_SRC-1:0]      clr_src;
  logic [N_SRC-1:0]      req_all;
  logic [N_SRC-1:0][1:0] lvl_all;
  logic [N_CRIT-1:0]     crit_q, crit_d;
  logic [N_EXT-1:0]      ext_en, ext_pend;
  lvl_t                  win_level, cur_level;

  assign ack_ok = ack & irq_valid;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      clr_src[i] = ack_ok && (irq_src == SRC_W'(i));
    end
  end

  // Latched level-3 events
  always_comb begin
    crit_d = crit_q;
    for (int c = 0; c < N_CRIT; c++) begin
      if (clr_src[c])  crit_d[c] = 1'b0;
      if (crit_evt[c]) crit_d[c] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crit_q <= '0;
    else        crit_q <= crit_d;
  end

  for (genvar k = 0; k < N_EXT; k++) begin : g_cfg
    assign ext_en[k] = field_on(ext_prio[2*k +: 2]);
  end

  irq_sense #(.N_EXT(N_EXT)) u_sense (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_n  (ext_req_n),
    .mode   (ext_mode),
    .enable (ext_en),
    .clr    (clr_src[N_SRC-1:N_CRIT]),
    .pend   (ext_pend)
  );

  for (genvar s = 0; s < N_SRC; s++) begin : g_map
    if (s < N_CRIT) begin : g_crit
      assign req_all[s] = crit_q[s];
      assign lvl_all[s] = LVL_TOP;
    end else begin : g_ext
      assign req_all[s] = ext_pend[s-N_CRIT];
      assign lvl_all[s] = field_to_lvl(ext_prio[2*(s-N_CRIT) +: 2]);
    end
  end

  irq_arbiter #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req_all),
    .lvl        (lvl_all),
    .thr        (mask_thr),
    .svc_active (svc_active),
    .svc_level  (cur_level),
    .valid      (irq_valid),
    .src        (irq_src),
    .level      (win_level)
  );

  irq_svc_track #(.N_LVL(4)) u_svc (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (ack_ok),
    .push_level (win_level),
    .pop        (eoi),
    .active     (svc_active),
    .level      (cur_level)
  );

  assign irq_level = win_level;
  assign svc_level = cur_level;

  AST_CRIT_PRESENTED: assert property (@(posedge clk) disable iff (!rst_n)
    ((|crit_q) && !(svc_active && svc_level == LVL_TOP)) |-> (irq_valid && irq_level == LVL_TOP)); // R4
  AST_IDLE_ACK_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_valid && !eoi) |=> (svc_active == $past(svc_active) && svc_level == $past(svc_level))); // R11

endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;

  localparam int N_CRIT = 2;
  localparam int N_EXT  = 4;
  localparam int SRC_W  = 3;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [N_CRIT-1:0]  crit_evt;
  logic [N_EXT-1:0]   ext_req_n, ext_mode;
  logic [2*N_EXT-1:0] ext_prio;
  logic [1:0]         mask_thr;
  logic               ack, eoi;
  logic               irq_valid, svc_active;
  logic [SRC_W-1:0]   irq_src;
  logic [1:0]         irq_level, svc_level;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl #(.N_CRIT(N_CRIT), .N_EXT(N_EXT)) u_prio_irq_ctrl (
    .clk, .rst_n, .crit_evt, .ext_req_n, .ext_mode, .ext_prio, .mask_thr,
    .ack, .eoi, .irq_valid, .irq_src, .irq_level, .svc_active, .svc_level
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic pulse_eoi();
    @(negedge clk); eoi = 1'b1;
    @(negedge clk); eoi = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; crit_evt = '0; ext_req_n = '1; ext_mode = '0; ext_prio = '0;
    mask_thr = 2'd0; ack = 1'b0; eoi = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid", irq_valid, 0);
    check("R1 svc_active", svc_active, 0);

    // R5: level sensing latency
    ext_prio[1:0] = 2'b01;
    @(negedge clk); ext_req_n[0] = 1'b0;
    @(negedge clk);
    check("R5 presented after one clock", irq_valid, 1);

    // R2/R3: every field against every threshold
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        @(negedge clk); ext_prio[1:0] = 2'(f); mask_thr = 2'(t);
        settle();
        check("R2/R3 valid", irq_valid, (f != 0 && (f - 1) >= t) ? 1 : 0);
        if (f != 0 && (f - 1) >= t) begin
          check("R2 level", irq_level, f - 1);
          check("R2 src", irq_src, 2);
        end
      end
    end
    mask_thr = 2'd0; ext_prio[1:0] = 2'b11;
    @(negedge clk); ext_req_n[0] = 1'b1;
    @(negedge clk);
    check("R5 withdrawn after one clock", irq_valid, 0);

    // R7: pairwise arbitration, ext0 (src 2) vs ext1 (src 3)
    ext_req_n[1:0] = 2'b00;
    for (int f0 = 1; f0 < 4; f0++) begin
      for (int f1 = 1; f1 < 4; f1++) begin
        @(negedge clk); ext_prio[1:0] = 2'(f0); ext_prio[3:2] = 2'(f1);
        settle();
        check("R7 src", irq_src, (f1 > f0) ? 3 : 2);
        check("R7 level", irq_level, ((f1 > f0) ? f1 : f0) - 1);
      end
    end
    ext_req_n = '1; ext_prio = '0;
    settle();

    // R11: ack with nothing presented
    check("R11 precondition", irq_valid, 0);
    pulse_ack();
    check("R11 svc_active", svc_active, 0);

    // R6: falling-edge sensing on ext2 (src 4), level 1
    ext_mode[2] = 1'b1; ext_prio[5:4] = 2'b10;
    @(negedge clk); ext_req_n[2] = 1'b0;
    @(negedge clk); ext_req_n[2] = 1'b1;
    settle();
    check("R6 latched valid", irq_valid, 1);
    check("R6 latched src", irq_src, 4);
    check("R6 latched level", irq_level, 1);
    pulse_ack();
    check("R8 svc_active", svc_active, 1);
    check("R8 svc_level", svc_level, 1);
    pulse_eoi();
    check("R10 svc cleared", svc_active, 0);
    check("R6 cleared by ack", irq_valid, 0);
    ext_prio[5:4] = 2'b00;
    @(negedge clk); ext_req_n[2] = 1'b0;
    @(negedge clk); ext_req_n[2] = 1'b1;
    settle();
    ext_prio[5:4] = 2'b10;
    settle();
    check("R6 edge while disabled discarded", irq_valid, 0);
    ext_prio = '0; ext_mode = '0;

    // R8/R9/R10/R4: nesting
    ext_prio[1:0] = 2'b10; ext_req_n[0] = 1'b0;
    settle();
    pulse_ack();
    check("R8 level1 in service", svc_level, 1);
    ext_prio[3:2] = 2'b10; ext_req_n[1] = 1'b0;
    settle();
    check("R9 equal level held off", irq_valid, 0);
    ext_prio[3:2] = 2'b11;
    settle();
    check("R9 higher presented", irq_valid, 1);
    check("R9 higher src", irq_src, 3);
    pulse_ack();
    check("R8 level2 in service", svc_level, 2);
    check("R9 nothing above 2", irq_valid, 0);
    mask_thr = 2'd3;
    @(negedge clk); crit_evt[1] = 1'b1;
    @(negedge clk); crit_evt[1] = 1'b0;
    settle();
    check("R4 crit valid", irq_valid, 1);
    check("R4 crit src", irq_src, 1);
    check("R4 crit level", irq_level, 3);
    mask_thr = 2'd0;
    pulse_ack();
    check("R8 level3 in service", svc_level, 3);
    pulse_eoi();
    check("R10 back to 2", svc_level, 2);
    check("R4 crit cleared", irq_valid, 0);
    pulse_eoi();
    check("R10 back to 1", svc_level, 1);
    check("R9 level2 reappears", irq_src, 3);
    pulse_eoi();
    check("R10 none left", svc_active, 0);
    check("R7 level2 wins after unwind", irq_level, 2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule